// File: doc/BRIEF.md
# Start-up and Auto-Restart Supervisor

This block is the digital sequencer of a self-supplied off-line switching converter. It reads comparator levels that have already been digitized and, where needed, given hysteresis outside the block. These levels cover the drain voltage, the supply thresholds, brown-out, thermal shutdown, overload, overvoltage and a per-cycle second-level overcurrent flag. From them it decides when the high-voltage start-up source charges the supply capacitor, at which current level it does so, and when the power switch may run.

Each start attempt charges the supply capacitor, then runs a soft-start during which a current-limit code rises linearly to full scale, and then enters normal running. A fault, or loss of the supply, stops switching. The block then waits for the supply to sink below a low restart level. From there it either recharges at a reduced current or, if the drain voltage has gone away, completes the power-down. A two-cycle qualifier turns repeated second-level overcurrent trips into a shutdown latch. Only the undervoltage level clears that latch.

Top module: `startup_supervisor`

## Requirements
- R1: `hv_en` is high only while the sequencer is charging (first charge or recharge) and `drain_ok` is high. From the idle state, a high `drain_ok` starts a charge in the next cycle.
- R2: `hv_low` is 0 on a first start and 1 on every recharge that follows a fault-driven shutdown. A shutdown caused only by `vdd_uv` does not set it. It returns to 0 when power-down ends in idle.
- R3: When `vdd_on` is seen during a charge with no fault present, the next cycle has `sw_en` high and `hv_en` low.
- R4: On entry to soft-start `ilim_code` is 0. It rises by 1 every PRESC clocks and reaches 2^CW-1 after (2^CW-1)*PRESC clocks, then holds while running. It is 0 whenever `sw_en` is low.
- R5: `sw_en` is high only in soft-start or run. It falls one cycle after `vdd_uv` or any fault is seen there.
- R6: After a shutdown the block waits until `vdd_rst` is high. It then recharges if `drain_ok` is high and goes idle otherwise. `flt_clr` is high exactly in the cycle in which `vdd_rst` ends the wait.
- R7: While switching, `ocp2_hit` at two consecutive `cyc_end` strobes sets `ocp_shut` one cycle after the second. A trip followed by a clean strobe does not set it. A set `ocp_shut` counts as a fault.
- R8: `ocp_shut` is cleared one cycle after `vdd_uv` is high.
- R9: The faults from brown-out (`br_ok` low), `therm_hot`, `olp_trip` and `ovp_trip` do not latch. If one of them is present when `vdd_on` arrives, no switching occurs and the block returns to waiting. Once the fault is gone, the next attempt soft-starts.
- R10: Loss of `drain_ok` during any charge returns the block to idle with `hv_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drain_ok | input | 1 | Drain voltage above start threshold |
| vdd_on | input | 1 | Supply at or above turn-on threshold |
| vdd_uv | input | 1 | Supply below undervoltage threshold |
| vdd_rst | input | 1 | Supply below restart threshold |
| br_ok | input | 1 | Input mains above brown-out level (hysteresis applied outside) |
| therm_hot | input | 1 | Thermal shutdown active (hysteresis applied outside) |
| olp_trip | input | 1 | Overload fault level |
| ovp_trip | input | 1 | Overvoltage fault level (already filtered) |
| cyc_end | input | 1 | One-clock strobe at each switching-cycle end |
| ocp2_hit | input | 1 | Second-level overcurrent seen in the ending cycle |
| hv_en | output | 1 | Enable of the high-voltage charge source |
| hv_low | output | 1 | Selects the reduced charge current |
| sw_en | output | 1 | Switching enable |
| ilim_code | output | CW | Current-limit code for soft-start and run |
| ocp_shut | output | 1 | Overcurrent shutdown latch |
| flt_clr | output | 1 | One-cycle clear pulse for external fault latches |

## Verification
The state and the overcurrent latch are registered. A level applied on one cycle therefore shows on `sw_en`, `hv_low`, `ocp_shut` and `ilim_code` one clock later. An overcurrent shutdown takes two clocks from the second tripping strobe to `sw_en` low, one for the latch and one for the sequencer. `hv_en` and `flt_clr` also follow `drain_ok` and `vdd_rst` in the same cycle. A behavioural model in the bench advances on each rising edge and is compared a quarter period later. Inputs change only on falling edges. The directed checks are placed at the clock count worked out above, including the (2^CW-1)*PRESC clocks of the soft-start ramp.

// File: rtl/sup_pkg.sv
// Shared types of the start-up supervisor.
package sup_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_SOFT   = 3'd2,
        ST_RUN    = 3'd3,
        ST_WAIT   = 3'd4,
        ST_RECHG  = 3'd5
    } sup_state_e;
endpackage

// File: rtl/sup_ss_ramp.sv
// Soft-start ramp: a prescaled counter whose code rises from zero to full
// scale, one step per PRESC clocks while enabled, and then holds.
// Assumes clr has priority and that en is only high after a clr period.
module sup_ss_ramp #(
    parameter int CW    = 8,
    parameter int PRESC = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] code,
    output logic          full
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESC - 1);

    logic [PW-1:0] pc;

    assign full = &code;

    // Advance the prescaler and step the code on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pc   <= '0;
            code <= '0;
        end else if (en && !full) begin
            if (pc == PLAST) begin
                pc   <= '0;
                code <= code + 1'b1;
            end else begin
                pc <= pc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_ocp_qual.sv
// Two-cycle second-level overcurrent qualifier. A trip at one cycle end
// arms a warning; a trip at the next cycle end sets the shutdown latch.
// Only counts while switching is enabled; clr (undervoltage) wins.
module sup_ocp_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic cyc_end,
    input  logic trip,
    input  logic clr,
    output logic shut
);
    logic warn;

    // Track whether the previous switching cycle ended with a trip.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            warn <= 1'b0;
        end else if (cyc_end) begin
            warn <= trip;
        end
    end

    // Set the shutdown latch on a second consecutive trip; clear on UV.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shut <= 1'b0;
        end else if (armed && cyc_end && trip && warn) begin
            shut <= 1'b1;
        end
    end
endmodule

// File: rtl/sup_seq_fsm.sv
// Start-up sequencer: idle, charge, soft-start, run, wait for restart level,
// recharge. Keeps a flag that marks starts following a fault.
// Assumes all inputs are synchronous, debounced levels.
module sup_seq_fsm
    import sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       drain_ok,
    input  logic       vdd_on,
    input  logic       vdd_uv,
    input  logic       vdd_rst,
    input  logic       any_fault,
    input  logic       ramp_full,
    output sup_state_e state,
    output logic       fault_seen,
    output logic       leave_wait
);
    sup_state_e nxt;
    logic       fs_nxt;

    assign leave_wait = (state == ST_WAIT) && vdd_rst;

    // Next-state and fault-flag decision.
    always_comb begin
        nxt    = state;
        fs_nxt = fault_seen;
        unique case (state)
            ST_IDLE: if (drain_ok) nxt = ST_CHARGE;
            ST_CHARGE, ST_RECHG: begin
                if (!drain_ok) begin
                    nxt    = ST_IDLE;
                    fs_nxt = 1'b0;
                end else if (vdd_on) begin
                    if (any_fault) begin
                        nxt    = ST_WAIT;
                        fs_nxt = 1'b1;
                    end else begin
                        nxt = ST_SOFT;
                    end
                end
            end
            ST_SOFT, ST_RUN: begin
                if (vdd_uv || any_fault) begin
                    nxt    = ST_WAIT;
                    fs_nxt = fault_seen || any_fault;
                end else if (state == ST_SOFT && ramp_full) begin
                    nxt = ST_RUN;
                end
            end
            ST_WAIT: begin
                if (vdd_rst) begin
                    if (drain_ok) begin
                        nxt = ST_RECHG;
                    end else begin
                        nxt    = ST_IDLE;
                        fs_nxt = 1'b0;
                    end
                end
            end
            default: begin
                nxt    = ST_IDLE;
                fs_nxt = 1'b0;
            end
        endcase
    end

    // State and fault-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            fault_seen <= 1'b0;
        end else begin
            state      <= nxt;
            fault_seen <= fs_nxt;
        end
    end
endmodule

// File: rtl/startup_supervisor.sv
// Top of the start-up and auto-restart supervisor. Combines the sequencer,
// the soft-start ramp and the overcurrent qualifier, and gates the outputs.
// Assumes every input is a clean level synchronous to clk.
module startup_supervisor
    import sup_pkg::*;
#(
    parameter int CW    = 8,
    parameter int PRESC = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drain_ok,
    input  logic          vdd_on,
    input  logic          vdd_uv,
    input  logic          vdd_rst,
    input  logic          br_ok,
    input  logic          therm_hot,
    input  logic          olp_trip,
    input  logic          ovp_trip,
    input  logic          cyc_end,
    input  logic          ocp2_hit,
    output logic          hv_en,
    output logic          hv_low,
    output logic          sw_en,
    output logic [CW-1:0] ilim_code,
    output logic          ocp_shut,
    output logic          flt_clr
);
    sup_state_e    state;
    logic          fault_seen;
    logic          any_fault;
    logic          charging;
    logic          ramp_full;
    logic [CW-1:0] ramp_code;

    assign any_fault = !br_ok || therm_hot || olp_trip || ovp_trip || ocp_shut;
    assign charging  = (state == ST_CHARGE) || (state == ST_RECHG);
    assign sw_en     = (state == ST_SOFT) || (state == ST_RUN);
    assign hv_en     = charging && drain_ok;
    assign hv_low    = fault_seen;
    assign ilim_code = sw_en ? ramp_code : '0;

    sup_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .drain_ok  (drain_ok),
        .vdd_on    (vdd_on),
        .vdd_uv    (vdd_uv),
        .vdd_rst   (vdd_rst),
        .any_fault (any_fault),
        .ramp_full (ramp_full),
        .state     (state),
        .fault_seen(fault_seen),
        .leave_wait(flt_clr)
    );

    sup_ss_ramp #(.CW(CW), .PRESC(PRESC)) u_ramp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!sw_en),
        .en   (state == ST_SOFT),
        .code (ramp_code),
        .full (ramp_full)
    );

    sup_ocp_qual u_ocp (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (sw_en),
        .cyc_end(cyc_end),
        .trip   (ocp2_hit),
        .clr    (vdd_uv),
        .shut   (ocp_shut)
    );
endmodule

// File: rtl/sup_chk.sv
// Property checker for the supervisor, attached by bind below.
module sup_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          drain_ok,
    input logic          vdd_uv,
    input logic          cyc_end,
    input logic          ocp2_hit,
    input logic          hv_en,
    input logic          sw_en,
    input logic [CW-1:0] ilim_code,
    input logic          ocp_shut,
    input logic          flt_clr
);
    // R1
    hv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> drain_ok);

    // R3
    hv_sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_en && sw_en));

    // R4
    ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && $past(sw_en)) |-> (ilim_code >= $past(ilim_code)));

    // R5
    uv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && vdd_uv) |=> !sw_en);

    // R7
    ocp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ocp_shut) |-> $past(cyc_end && ocp2_hit && sw_en));

    // R8
    ocp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |=> !ocp_shut);

    // R6
    clr_nosw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> !sw_en);
endmodule

bind startup_supervisor sup_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .drain_ok (drain_ok),
    .vdd_uv   (vdd_uv),
    .cyc_end  (cyc_end),
    .ocp2_hit (ocp2_hit),
    .hv_en    (hv_en),
    .sw_en    (sw_en),
    .ilim_code(ilim_code),
    .ocp_shut (ocp_shut),
    .flt_clr  (flt_clr)
);

// File: tb/sim_startup_supervisor.sv
module sim_startup_supervisor;
    localparam int TCK   = 10;
    localparam int CW    = 4;
    localparam int PRESC = 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drain_ok = 0, vdd_on = 0, vdd_uv = 0, vdd_rst = 0;
    logic br_ok = 1, therm_hot = 0, olp_trip = 0, ovp_trip = 0;
    logic cyc_end = 0, ocp2_hit = 0;
    logic hv_en, hv_low, sw_en, ocp_shut, flt_clr;
    logic [CW-1:0] ilim_code;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // model state: 0 idle,1 charge,2 soft,3 run,4 wait,5 recharge
    int  m_st = 0;
    bit  m_fs = 0;
    int  m_pc = 0;
    int  m_code = 0;
    bit  m_warn = 0;
    bit  m_shut = 0;

    always #(TCK/2) clk = ~clk;

    startup_supervisor #(.CW(CW), .PRESC(PRESC)) u0 (
        .clk(clk), .rst_n(rst_n), .drain_ok(drain_ok), .vdd_on(vdd_on),
        .vdd_uv(vdd_uv), .vdd_rst(vdd_rst), .br_ok(br_ok),
        .therm_hot(therm_hot), .olp_trip(olp_trip), .ovp_trip(ovp_trip),
        .cyc_end(cyc_end), .ocp2_hit(ocp2_hit), .hv_en(hv_en),
        .hv_low(hv_low), .sw_en(sw_en), .ilim_code(ilim_code),
        .ocp_shut(ocp_shut), .flt_clr(flt_clr)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model: advance on each edge, compare a quarter period later.
    always @(posedge clk) begin
        bit f, sw, nw, ns, fs;
        int st, pc, cd;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_fs = 0; m_pc = 0; m_code = 0; m_warn = 0; m_shut = 0;
        end else begin
            f  = !br_ok || therm_hot || olp_trip || ovp_trip || m_shut;
            sw = (m_st == 2 || m_st == 3);
            nw = !sw ? 0 : (cyc_end ? ocp2_hit : m_warn);
            ns = vdd_uv ? 0 : ((sw && cyc_end && ocp2_hit && m_warn) ? 1 : m_shut);
            pc = m_pc; cd = m_code;
            if (!sw) begin pc = 0; cd = 0; end
            else if (m_st == 2 && m_code < CMAX) begin
                if (m_pc == PRESC - 1) begin pc = 0; cd = m_code + 1; end
                else pc = m_pc + 1;
            end
            st = m_st; fs = m_fs;
            case (m_st)
                0: if (drain_ok) st = 1;
                1, 5: if (!drain_ok) begin st = 0; fs = 0; end
                      else if (vdd_on) begin
                          if (f) begin st = 4; fs = 1; end else st = 2;
                      end
                2, 3: if (vdd_uv || f) begin st = 4; fs = m_fs || f; end
                      else if (m_st == 2 && m_code == CMAX) st = 3;
                4: if (vdd_rst) begin
                       if (drain_ok) st = 5; else begin st = 0; fs = 0; end
                   end
                default: st = 0;
            endcase
            m_st = st; m_fs = fs; m_pc = pc; m_code = cd; m_warn = nw; m_shut = ns;
        end
        #(TCK/4);
        chk(int'(hv_en), int'((m_st == 1 || m_st == 5) && drain_ok), "R1 hv_en model");
        chk(int'(hv_low), int'(m_fs), "R2 hv_low model");
        chk(int'(sw_en), int'(m_st == 2 || m_st == 3), "R5 sw_en model");
        chk(int'(ilim_code), (m_st == 2 || m_st == 3) ? m_code : 0, "R4 ilim_code model");
        chk(int'(ocp_shut), int'(m_shut), "R7 ocp_shut model");
        chk(int'(flt_clr), int'(m_st == 4 && vdd_rst), "R6 flt_clr model");
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic ocp_cycle(input bit hit);
        cyc_end = 1; ocp2_hit = hit;
        step(1);
        cyc_end = 0; ocp2_hit = 0;
        step(2);
    endtask

    initial begin
        step(3);
        chk(int'(hv_en), 0, "R1 reset hv_en");
        chk(int'(sw_en), 0, "R5 reset sw_en");
        chk(int'(ocp_shut), 0, "R7 reset ocp_shut");
        rst_n = 1;
        step(3);
        chk(int'(hv_en), 0, "R1 idle without drain");
        drain_ok = 1; step(1);
        chk(int'(hv_en), 1, "R1 charge starts");
        chk(int'(hv_low), 0, "R2 first start normal current");
        drain_ok = 0; step(1);
        chk(int'(hv_en), 0, "R10 drain lost");
        drain_ok = 1; step(1);
        chk(int'(hv_en), 1, "R10 charge resumes from idle");
        vdd_on = 1; step(1);
        vdd_on = 0;
        chk(int'(sw_en), 1, "R3 switching on");
        chk(int'(hv_en), 0, "R3 charge off");
        chk(int'(ilim_code), 0, "R4 ramp starts at zero");
        step(PRESC);
        chk(int'(ilim_code), 1, "R4 first step");
        step(CMAX * PRESC);
        chk(int'(ilim_code), CMAX, "R4 full scale in run");
        ocp_cycle(1);
        ocp_cycle(0);
        chk(int'(ocp_shut), 0, "R7 isolated trip ignored");
        ocp_cycle(1);
        cyc_end = 1; ocp2_hit = 1; step(1);
        cyc_end = 0; ocp2_hit = 0;
        chk(int'(ocp_shut), 1, "R7 two trips latch");
        step(1);
        chk(int'(sw_en), 0, "R7 latch stops switching");
        vdd_uv = 1; step(1);
        vdd_uv = 0;
        chk(int'(ocp_shut), 0, "R8 latch cleared by UV");
        vdd_rst = 1; #1;
        chk(int'(flt_clr), 1, "R6 clear pulse");
        step(1);
        vdd_rst = 0;
        chk(int'(hv_en), 1, "R6 recharge");
        chk(int'(hv_low), 1, "R2 reduced current after fault");
        br_ok = 0; vdd_on = 1; step(1);
        vdd_on = 0;
        chk(int'(sw_en), 0, "R9 brown-out blocks start");
        chk(int'(hv_en), 0, "R9 back to wait");
        br_ok = 1; vdd_rst = 1; step(1);
        vdd_rst = 0;
        vdd_on = 1; step(1);
        vdd_on = 0;
        chk(int'(sw_en), 1, "R9 restart after brown-out");
        step(CMAX * PRESC + 4);
        therm_hot = 1; step(2);
        therm_hot = 0;
        chk(int'(sw_en), 0, "R5 thermal stop");
        drain_ok = 0; vdd_rst = 1; step(1);
        vdd_rst = 0;
        chk(int'(hv_en), 0, "R6 power-down to idle");
        chk(int'(hv_low), 0, "R2 flag cleared at idle");
        drain_ok = 1; step(1);
        vdd_on = 1; step(1);
        vdd_on = 0;
        step(3);
        vdd_uv = 1; step(1);
        vdd_uv = 0;
        chk(int'(sw_en), 0, "R5 UV stops soft-start");
        vdd_rst = 1; step(1);
        vdd_rst = 0;
        chk(int'(hv_low), 0, "R2 plain UV keeps normal current");
        chk(int'(hv_en), 1, "R6 recharge after UV");
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule